// File: doc/BRIEF.md
# Flash Line-Buffer Accelerator Tag Tracker

This block sits in front of an on-chip flash array and decides, for every access, whether the requested word is already held in one of the line buffers or whether a full flash read is needed. Each request carries an address, an access kind (sequential instruction prefetch, branch target fetch, or data load) and a mode setting. One clock later the block returns the number of wait cycles the access costs and a flag that says whether a buffer served it.

The block does not hold the flash data itself. It holds only the line tags for three buffer classes: a prefetch buffer and a branch trail buffer in each of two interleaved banks, and a single data buffer. The bank is chosen by the address bit that the preload offset of 128 bytes flips. When an instruction fetch misses, the line 128 bytes further on is preloaded into the opposite bank. A saturating hit counter and a saturating miss counter are kept for each access kind, so the hit rate of a code layout can be measured.

Top module: `fma_line_accel`

## Requirements
- R1: An access with either of the two top address bits set goes to RAM or peripherals. It costs 1 wait cycle and reports no hit. It changes no tag and no counter.
- R2: In mode 0 (off), every flash access costs FLASH_WAIT cycles and reports no hit. It counts as a miss of its kind, and no tag changes.
- R3: In mode 3 (full speed), every flash access costs 1 cycle and reports a hit. It counts as a hit of its kind, and no tag changes.
- R4: In a buffered mode, a prefetch (kind 0) hits when its line (address bits above bit 3) equals the valid prefetch tag or the valid branch tag of its bank (address bit 7). On a miss only that bank's prefetch tag is replaced.
- R5: In a buffered mode, a branch fetch (kind 1) uses the same hit test. On a miss, its bank's branch tag takes its line, and the other bank's branch tag takes the line of address+0x80.
- R6: In a buffered mode, every prefetch sets the other bank's prefetch tag to the line of address+0x80, whether it hits or misses.
- R7: A data access (kind 2, and kind 3 treated alike) tests and replaces only the data tag. It never hits on, or changes, an instruction tag.
- R8: In mode 1 (partial), data accesses cost FLASH_WAIT, report no hit, count as data misses and leave the data tag unchanged. Instruction fetches are buffered as in mode 2.
- R9: A buffered flash hit costs 1 cycle and a buffered miss costs FLASH_WAIT, which is 3 or 4.
- R10: Reset invalidates all tags and clears all six counters, so the first flash access of each kind in a buffered mode is a miss.
- R11: A change of the mode input invalidates all tags. A request in the same cycle sees the tags empty.
- R12: Each counter stops at its all-ones value and otherwise increments by one per counted access of its kind.
- R13: The response valid, wait count and hit flag are registered: they appear exactly one clock after the request strobe, and valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 0 off, 1 partial, 2 buffered, 3 full speed |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | AW | Byte address of the access |
| req_kind_i | input | 2 | 0 prefetch, 1 branch target, 2 or 3 data |
| rsp_valid_o | output | 1 | Response present, one clock after the strobe |
| rsp_wait_o | output | 3 | Wait cycles the access costs |
| rsp_hit_o | output | 1 | The access was served by a buffer |
| hit_cnt_o | output | 3*CW | Hit counters {data, branch, prefetch} |
| miss_cnt_o | output | 3*CW | Miss counters {data, branch, prefetch} |

## Verification
On every cycle the assertions check the timing and cost rules: the response follows the strobe by one clock, RAM accesses cost one cycle, a hit always costs one cycle, the off mode never hits, data accesses leave the instruction tags unchanged, and counters hold at saturation and move only when incremented. The lookup itself can only be shown by scenarios that the bench drives against its own tag model. These include a preloaded line hitting in the opposite bank, a branch tag serving a later prefetch, a prefetch miss leaving the branch tag in place, the effect of flushes on mode change and on reset, and counter saturation over long runs.

// File: rtl/fma_pkg.sv
package fma_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_PART = 2'd1,
      MODE_BANK = 2'd2,
      MODE_FULL = 2'd3
   } fma_mode_e;

   typedef enum logic [1:0] {
      KIND_PF   = 2'd0,
      KIND_BR   = 2'd1,
      KIND_DATA = 2'd2
   } fma_kind_e;

   localparam int NKIND = 3;
   localparam int WAIT_W = 3;
endpackage

// File: rtl/fma_tag_slot.sv
module fma_tag_slot #(
   parameter int TW = 28
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          load_i,
   input  logic [TW-1:0] tag_i,
   output logic          valid_o,
   output logic [TW-1:0] tag_o
);
   if (TW < 1) begin : g_bad_tw
      $error("fma_tag_slot: TW must be positive");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         tag_o   <= '0;
      end else begin
         if (load_i) begin
            valid_o <= 1'b1;
            tag_o   <= tag_i;
         end else if (flush_i) begin
            valid_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/fma_sat_cnt.sv
module fma_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 2) begin : g_bad_w
      $error("fma_sat_cnt: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                    cnt_o <= '0;
      else if (inc_i && cnt_o != TOP) cnt_o <= cnt_o + 1'b1;
   end

   // R12
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o == TOP |=> cnt_o == TOP);
   // R12
   idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !inc_i |=> $stable(cnt_o));
   // R12
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && cnt_o != TOP) |=> cnt_o == $past(cnt_o) + 1'b1);
endmodule

// File: rtl/fma_line_accel.sv
module fma_line_accel #(
   parameter int AW         = 32,
   parameter int LINE_BYTES = 16,
   parameter int NEXT_OFS   = 128,
   parameter int FLASH_WAIT = 3,
   parameter int CW         = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode_i,
   input  logic                  req_valid_i,
   input  logic [AW-1:0]         req_addr_i,
   input  logic [1:0]            req_kind_i,
   output logic                  rsp_valid_o,
   output logic [2:0]            rsp_wait_o,
   output logic                  rsp_hit_o,
   output logic [3*CW-1:0]       hit_cnt_o,
   output logic [3*CW-1:0]       miss_cnt_o
);
   import fma_pkg::*;

   localparam int OFS_W    = $clog2(LINE_BYTES);
   localparam int TW       = AW - OFS_W;
   localparam int BANK_BIT = $clog2(NEXT_OFS);
   localparam int STEP     = NEXT_OFS / LINE_BYTES;
   localparam logic [WAIT_W-1:0] MISS_W = WAIT_W'(FLASH_WAIT);
   localparam logic [WAIT_W-1:0] ONE_W  = WAIT_W'(1);

   if (FLASH_WAIT != 3 && FLASH_WAIT != 4) begin : g_bad_wait
      $error("fma_line_accel: FLASH_WAIT must be 3 or 4");
   end
   if ((1 << OFS_W) != LINE_BYTES || (1 << BANK_BIT) != NEXT_OFS) begin : g_bad_pow
      $error("fma_line_accel: LINE_BYTES and NEXT_OFS must be powers of two");
   end
   if (NEXT_OFS <= LINE_BYTES || BANK_BIT >= AW - 2) begin : g_bad_ofs
      $error("fma_line_accel: NEXT_OFS must exceed a line and stay below the region bits");
   end

   // ---------------- request decode ----------------
   logic [TW-1:0] line, nline;
   logic          bank, is_ram, is_pf, is_br, is_data;
   logic [1:0]    mode_q;
   logic          mode_chg;
   wire           unused_lo = ^req_addr_i[OFS_W-1:0];

   assign line     = req_addr_i[AW-1:OFS_W];
   assign nline    = line + TW'(STEP);
   assign bank     = req_addr_i[BANK_BIT];
   assign is_ram   = |req_addr_i[AW-1:AW-2];
   assign is_pf    = (req_kind_i == KIND_PF);
   assign is_br    = (req_kind_i == KIND_BR);
   assign is_data  = req_kind_i[1];
   assign mode_chg = (mode_i != mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= MODE_OFF;
      else        mode_q <= mode_i;
   end

   // ---------------- tag storage ----------------
   logic [1:0]          pf_v, br_v, pf_ld, br_ld;
   logic [1:0][TW-1:0]  pf_tag, br_tag, pf_in, br_in;
   logic                dt_v, dt_ld;
   logic [TW-1:0]       dt_tag;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      fma_tag_slot #(.TW(TW)) u_pf (
         .clk(clk), .rst_n(rst_n), .flush_i(mode_chg), .load_i(pf_ld[b]),
         .tag_i(pf_in[b]), .valid_o(pf_v[b]), .tag_o(pf_tag[b]));
      fma_tag_slot #(.TW(TW)) u_br (
         .clk(clk), .rst_n(rst_n), .flush_i(mode_chg), .load_i(br_ld[b]),
         .tag_i(br_in[b]), .valid_o(br_v[b]), .tag_o(br_tag[b]));
      assign pf_in[b] = (b == int'(bank)) ? line : nline;
      assign br_in[b] = (b == int'(bank)) ? line : nline;
   end

   fma_tag_slot #(.TW(TW)) u_dt (
      .clk(clk), .rst_n(rst_n), .flush_i(mode_chg), .load_i(dt_ld),
      .tag_i(line), .valid_o(dt_v), .tag_o(dt_tag));

   // ---------------- lookup ----------------
   logic instr_hit, data_hit, buffered, act_buf;

   assign instr_hit = !mode_chg &&
                      ((pf_v[bank] && pf_tag[bank] == line) ||
                       (br_v[bank] && br_tag[bank] == line));
   assign data_hit  = !mode_chg && dt_v && dt_tag == line;
   assign buffered  = (mode_i == MODE_BANK) || (mode_i == MODE_PART && !is_data);
   assign act_buf   = req_valid_i && !is_ram && buffered;

   always_comb begin
      for (int b = 0; b < 2; b++) begin
         pf_ld[b] = act_buf && is_pf && ((b != int'(bank)) || !instr_hit);
         br_ld[b] = act_buf && is_br && !instr_hit;
      end
   end
   assign dt_ld = act_buf && is_data && !data_hit;

   // ---------------- cost and result ----------------
   logic             hit_now, counted;
   logic [WAIT_W-1:0] wait_now;

   always_comb begin
      hit_now  = 1'b0;
      wait_now = MISS_W;
      counted  = req_valid_i && !is_ram;
      if (is_ram) begin
         wait_now = ONE_W;
      end else if (mode_i == MODE_FULL) begin
         hit_now  = 1'b1;
         wait_now = ONE_W;
      end else if (buffered) begin
         hit_now  = is_data ? data_hit : instr_hit;
         wait_now = hit_now ? ONE_W : MISS_W;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_wait_o  <= '0;
         rsp_hit_o   <= 1'b0;
      end else begin
         rsp_valid_o <= req_valid_i;
         if (req_valid_i) begin
            rsp_wait_o <= wait_now;
            rsp_hit_o  <= hit_now;
         end
      end
   end

   // ---------------- counters ----------------
   logic [NKIND-1:0] kind_sel;
   assign kind_sel = {is_data, is_br, is_pf};

   for (genvar k = 0; k < NKIND; k++) begin : g_cnt
      fma_sat_cnt #(.W(CW)) u_hit (
         .clk(clk), .rst_n(rst_n), .inc_i(counted && kind_sel[k] && hit_now),
         .cnt_o(hit_cnt_o[k*CW +: CW]));
      fma_sat_cnt #(.W(CW)) u_miss (
         .clk(clk), .rst_n(rst_n), .inc_i(counted && kind_sel[k] && !hit_now),
         .cnt_o(miss_cnt_o[k*CW +: CW]));
   end

   // ---------------- assertions ----------------
   // R1
   ram_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && is_ram) |=> (rsp_wait_o == ONE_W && !rsp_hit_o));
   // R2
   off_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !is_ram && mode_i == MODE_OFF) |=> (!rsp_hit_o && rsp_wait_o == MISS_W));
   // R9
   hit_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid_o && rsp_hit_o) |-> rsp_wait_o == ONE_W);
   // R7
   data_keeps_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && is_data && !mode_chg) |=> ($stable(pf_tag) && $stable(br_tag)
                                                 && $stable(pf_v) && $stable(br_v)));
   // R11
   flush_on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_chg && !req_valid_i) |=> (pf_v == 2'b00 && br_v == 2'b00 && !dt_v));
   // R13
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> rsp_valid_o == $past(req_valid_i));
endmodule

// File: tb/sim_fma_line_accel.sv
module sim_fma_line_accel;
   localparam int CLK_P = 10;
   localparam int WAIT  = 3;
   localparam int CW    = 4;
   localparam int CMAX  = 15;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        mode = 2'd0;
   logic              req_valid = 1'b0;
   logic [31:0]       req_addr = '0;
   logic [1:0]        req_kind = '0;
   logic              rsp_valid, rsp_hit;
   logic [2:0]        rsp_wait;
   logic [3*CW-1:0]   hit_cnt, miss_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // bench model of the tag state
   bit pf_v[2], br_v[2], dt_v;
   int pf_t[2], br_t[2], dt_t;
   int ehit[3], emiss[3];
   int mmode = 0;

   always #(CLK_P/2) clk = ~clk;

   fma_line_accel #(.AW(32), .LINE_BYTES(16), .NEXT_OFS(128),
                    .FLASH_WAIT(WAIT), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_valid_i(req_valid),
      .req_addr_i(req_addr), .req_kind_i(req_kind), .rsp_valid_o(rsp_valid),
      .rsp_wait_o(rsp_wait), .rsp_hit_o(rsp_hit), .hit_cnt_o(hit_cnt),
      .miss_cnt_o(miss_cnt));

   task automatic chk(input string rq, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic void flush_model();
      for (int b = 0; b < 2; b++) begin pf_v[b] = 0; br_v[b] = 0; end
      dt_v = 0;
   endfunction

   function automatic void bump(input int k, input bit h);
      if (h) begin if (ehit[k] < CMAX) ehit[k]++; end
      else   begin if (emiss[k] < CMAX) emiss[k]++; end
   endfunction

   task automatic set_mode(input int m);
      @(negedge clk);
      mode = 2'(m);
      if (m != mmode) flush_model();
      mmode = m;
   endtask

   task automatic access(input int k, input logic [31:0] a, input string rq);
      int  ln, nl, b, ew;
      bit  eh, ih;
      int  kk;
      kk = (k >= 2) ? 2 : k;
      ln = int'(a >> 4);
      nl = int'((a + 32'h80) >> 4);
      b  = int'(a[7]);
      eh = 0;
      ew = WAIT;
      if (a[31:30] != 0) begin
         ew = 1;
      end else if (mmode == 0) begin
         bump(kk, 0);
      end else if (mmode == 3) begin
         eh = 1; ew = 1; bump(kk, 1);
      end else if (mmode == 1 && kk == 2) begin
         bump(kk, 0);
      end else begin
         ih = (pf_v[b] && pf_t[b] == ln) || (br_v[b] && br_t[b] == ln);
         if (kk == 0) begin
            eh = ih;
            pf_v[1-b] = 1; pf_t[1-b] = nl;
            if (!ih) begin pf_v[b] = 1; pf_t[b] = ln; end
         end else if (kk == 1) begin
            eh = ih;
            if (!ih) begin
               br_v[b] = 1; br_t[b] = ln;
               br_v[1-b] = 1; br_t[1-b] = nl;
            end
         end else begin
            eh = dt_v && dt_t == ln;
            if (!eh) begin dt_v = 1; dt_t = ln; end
         end
         if (eh) ew = 1;
         bump(kk, eh);
      end
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_kind = 2'(k);
      @(negedge clk);
      req_valid = 1'b0;
      chk({rq, " valid (R13)"}, int'(rsp_valid), 1);
      chk({rq, " wait"}, int'(rsp_wait), ew);
      chk({rq, " hit"}, int'(rsp_hit), int'(eh));
      chk({rq, " hit count"}, int'(hit_cnt[kk*CW +: CW]), ehit[kk]);
      chk({rq, " miss count"}, int'(miss_cnt[kk*CW +: CW]), emiss[kk]);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      mode = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      flush_model();
      mmode = 0;
      for (int k = 0; k < 3; k++) begin ehit[k] = 0; emiss[k] = 0; end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int r;
      do_reset();
      // R10: reset state
      chk("R10 rsp_valid after reset", int'(rsp_valid), 0);
      chk("R10 hit counters cleared", int'(hit_cnt), 0);
      chk("R10 miss counters cleared", int'(miss_cnt), 0);

      set_mode(2);
      access(0, 32'h100, "R10 first prefetch");
      chk("R10 first prefetch misses", int'(rsp_hit), 0);
      chk("R9 miss costs FLASH_WAIT", int'(rsp_wait), WAIT);
      access(0, 32'h180, "R6 preload");
      chk("R6 preloaded line hits in other bank", int'(rsp_hit), 1);
      chk("R9 hit costs one cycle", int'(rsp_wait), 1);
      access(1, 32'h400, "R5 branch miss");
      chk("R5 branch first miss", int'(rsp_hit), 0);
      access(1, 32'h480, "R5 branch trail other bank");
      chk("R5 other bank branch tag preloaded", int'(rsp_hit), 1);
      access(0, 32'h404, "R4 prefetch on branch tag");
      chk("R4 prefetch hits branch tag", int'(rsp_hit), 1);
      access(0, 32'h000, "R4 prefetch miss");
      chk("R4 prefetch miss", int'(rsp_hit), 0);
      access(1, 32'h408, "R4 branch tag kept");
      chk("R4 branch tag not replaced by prefetch miss", int'(rsp_hit), 1);
      access(2, 32'h400, "R7 data ignores instr tags");
      chk("R7 data misses despite instr tag", int'(rsp_hit), 0);
      access(3, 32'h40C, "R7 data repeat");
      chk("R7 data tag hit", int'(rsp_hit), 1);
      access(0, 32'h480, "R7 instr tags kept");
      chk("R7 branch tag still present after data", int'(rsp_hit), 1);

      set_mode(1);
      access(0, 32'h480, "R11 flush on mode change");
      chk("R11 tags invalid after mode change", int'(rsp_hit), 0);
      access(2, 32'h480, "R8 partial data");
      access(2, 32'h480, "R8 partial data repeat");
      chk("R8 partial data never hits", int'(rsp_hit), 0);
      chk("R8 partial data full wait", int'(rsp_wait), WAIT);
      access(0, 32'h484, "R8 partial instr buffered");
      chk("R8 partial instr hits", int'(rsp_hit), 1);

      set_mode(3);
      access(2, 32'h12340, "R3 full mode");
      chk("R3 full mode hit", int'(rsp_hit), 1);
      access(1, 32'h8000_0010, "R1 peripheral");
      chk("R1 peripheral one cycle", int'(rsp_wait), 1);
      chk("R1 peripheral no hit", int'(rsp_hit), 0);

      set_mode(0);
      access(0, 32'h0, "R2 off mode");
      chk("R2 off mode miss", int'(rsp_hit), 0);
      @(negedge clk);
      chk("R13 no response without request", int'(rsp_valid), 0);
      for (int i = 0; i < 20; i++) access(2, 32'h200, "R12 saturate");
      chk("R12 data miss counter saturated", int'(miss_cnt[2*CW +: CW]), CMAX);

      // sweep: all modes, all kinds, a small line pool plus RAM
      r = 7;
      for (int m = 0; m < 4; m++) begin
         do_reset();
         set_mode(m);
         for (int i = 0; i < 90; i++) begin
            logic [31:0] a;
            r = (r * 1103515245 + 12345) & 32'h7fffffff;
            a = 32'((r >> 8) % 24) << 4;
            a = a | 32'((r >> 4) & 32'hC);
            if (((r >> 16) % 9) == 0) a = a | 32'h4000_0000;
            access((r >> 20) % 4, a, "R4 R5 R6 R7 R9 R12 sweep");
         end
      end

      // R10: reset in the middle of a run clears tags
      set_mode(2);
      access(0, 32'h300, "R10 before reset");
      access(0, 32'h300, "R10 warm");
      do_reset();
      set_mode(2);
      access(0, 32'h300, "R10 after reset");
      chk("R10 tag cleared by reset", int'(rsp_hit), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule